// File: doc/BRIEF.md
# General-Purpose Register Bank with Result Pair

A register store for a small load-store processor core. It keeps thirty-two 32-bit general registers plus two separate 32-bit result registers, an upper and a lower half, that hold multiply and divide results. Two read ports return data in the same cycle as their address. One write port updates a register on the rising clock edge. Reads of index 0 always return zero, and writes to index 0 change nothing.

Besides the explicit write, three more paths reach the storage. A link path writes a return address into the top register (index 31) without naming it. This is the path a jump-and-link-register instruction uses. A pair path loads both result registers at once from a multiply or divide unit. Move operations copy a value into either result register alone, or copy either result register into a general register through the normal write port. Forwarding across pipeline stages and instruction decode sit outside this block.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous active-high reset clears every general register and both result registers to zero.
- R2: With `wr_en` high, `link_en` low and `wr_sel` at 0 or 3, `wr_data` is written to register `wr_addr` at the rising edge. Both read ports show it from then on.
- R3: A read of index 0 returns zero on either port, even after a write to index 0.
- R4: If the effective write targets a nonzero register that a read port addresses in the same cycle, that port returns the value being written (write-first).
- R5: With `link_en` high, `link_data` is written to register 31 at the edge, whatever `wr_addr` holds.
- R6: With `link_en` and `wr_en` both high, the explicit write is dropped entirely for that cycle. Only register 31 changes.
- R7: `hl_op` = 1 loads `prod_hi` into the upper result register and `prod_lo` into the lower one at the same edge.
- R8: `hl_op` = 2 loads `hl_move_data` into the upper result register only. `hl_op` = 3 loads it into the lower result register only. `hl_op` = 0 holds both.
- R9: `wr_sel` = 1 writes the current upper result register, and `wr_sel` = 2 the current lower one, into general register `wr_addr`. Each uses the value from before the edge.
- R10: With `wr_en` and `link_en` both low, no general register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Explicit write enable |
| wr_addr | input | 5 | Explicit write index |
| wr_sel | input | 2 | Write source: 0/3 bus, 1 upper result, 2 lower result |
| wr_data | input | 32 | Explicit write data |
| link_en | input | 1 | Implicit link write to register 31 |
| link_data | input | 32 | Return address for link write |
| hl_op | input | 2 | Result register op: 0 hold, 1 pair, 2 set upper, 3 set lower |
| prod_hi | input | 32 | Upper word from multiply/divide |
| prod_lo | input | 32 | Lower word from multiply/divide |
| hl_move_data | input | 32 | Data for move into one result register |
| hi_q | output | 32 | Upper result register |
| lo_q | output | 32 | Lower result register |

## Verification
The bench builds the block with its default values: 32 registers of 32 bits, so register 31 is the link target and index width is 5. With only 32 entries, a few thousand random cycles hit every index many times. They also often produce collisions between the read and write indices, and between link and explicit writes. Directed cases add the index-0 write, the link collision on both register 31 and other indices, and move-from in the same cycle as a result register update.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;

    localparam int unsigned DFLT_DATA_W = 32;
    localparam int unsigned DFLT_NREGS  = 32;

    typedef enum logic [1:0] {
        HL_IDLE   = 2'd0,
        HL_PAIR   = 2'd1,
        HL_SET_HI = 2'd2,
        HL_SET_LO = 2'd3
    } hl_op_e;

    typedef enum logic [1:0] {
        WS_BUS  = 2'd0,
        WS_HI   = 2'd1,
        WS_LO   = 2'd2,
        WS_BUS2 = 2'd3
    } wr_src_e;

    function automatic logic hl_touches_hi(hl_op_e op);
        return (op == HL_PAIR) || (op == HL_SET_HI);
    endfunction

    function automatic logic hl_touches_lo(hl_op_e op);
        return (op == HL_PAIR) || (op == HL_SET_LO);
    endfunction

endpackage

// File: rtl/gpr_write_arb.sv
module gpr_write_arb
    import gpr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W,
    parameter int unsigned NREGS  = DFLT_NREGS,
    localparam int unsigned ADDR_W = $clog2(NREGS)
) (
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wr_src_e           wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_data,
    input  logic [DATA_W-1:0] hi_cur,
    input  logic [DATA_W-1:0] lo_cur,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [ADDR_W-1:0] LINK_IDX = ADDR_W'(NREGS - 1);

    always_comb begin
        we    = 1'b0;
        waddr = wr_addr;
        wdata = wr_data;
        if (!rst) begin
            if (link_en) begin
                we    = 1'b1;
                waddr = LINK_IDX;
                wdata = link_data;
            end else if (wr_en) begin
                we = 1'b1;
                unique case (wr_sel)
                    WS_HI:   wdata = hi_cur;
                    WS_LO:   wdata = lo_cur;
                    default: wdata = wr_data;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpr_array.sv
module gpr_array
    import gpr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W,
    parameter int unsigned NREGS  = DFLT_NREGS,
    parameter int unsigned NRD    = 2,
    localparam int unsigned ADDR_W = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NRD*ADDR_W-1:0]    raddr,
    output logic [NRD*DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREGS); i++) mem[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        logic [ADDR_W-1:0] ra;
        logic [DATA_W-1:0] rd;
        assign ra = raddr[p*ADDR_W +: ADDR_W];
        always_comb begin
            if (ra == '0)                   rd = '0;
            else if (we && (waddr == ra))   rd = wdata;
            else                            rd = mem[ra];
        end
        assign rdata[p*DATA_W +: DATA_W] = rd;
    end
endmodule

// File: rtl/hilo_regs.sv
module hilo_regs
    import gpr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  hl_op_e            op,
    input  logic [DATA_W-1:0] pair_hi,
    input  logic [DATA_W-1:0] pair_lo,
    input  logic [DATA_W-1:0] move_data,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hl_touches_hi(op)) hi_q <= (op == HL_PAIR) ? pair_hi : move_data;
            if (hl_touches_lo(op)) lo_q <= (op == HL_PAIR) ? pair_lo : move_data;
        end
    end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W,
    parameter int unsigned NREGS  = DFLT_NREGS,
    localparam int unsigned ADDR_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_data,
    input  logic [1:0]        hl_op,
    input  logic [DATA_W-1:0] prod_hi,
    input  logic [DATA_W-1:0] prod_lo,
    input  logic [DATA_W-1:0] hl_move_data,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] lo_q
);
    localparam int unsigned NRD = 2;

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [NRD*DATA_W-1:0] rdata;

    gpr_write_arb #(.DATA_W(DATA_W), .NREGS(NREGS)) u_arb (
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_sel    (wr_src_e'(wr_sel)),
        .wr_data   (wr_data),
        .link_en   (link_en),
        .link_data (link_data),
        .hi_cur    (hi_q),
        .lo_cur    (lo_q),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata)
    );

    gpr_array #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(NRD)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr ({rd_addr_b, rd_addr_a}),
        .rdata (rdata)
    );

    assign rd_data_a = rdata[0 +: DATA_W];
    assign rd_data_b = rdata[DATA_W +: DATA_W];

    hilo_regs #(.DATA_W(DATA_W)) u_hilo (
        .clk       (clk),
        .rst       (rst),
        .op        (hl_op_e'(hl_op)),
        .pair_hi   (prod_hi),
        .pair_lo   (prod_lo),
        .move_data (hl_move_data),
        .hi_q      (hi_q),
        .lo_q      (lo_q)
    );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREGS  = 32,
    localparam int unsigned ADDR_W = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_en,
    input logic [DATA_W-1:0] link_data,
    input logic [1:0]        hl_op,
    input logic [DATA_W-1:0] prod_hi,
    input logic [DATA_W-1:0] prod_lo,
    input logic [DATA_W-1:0] hl_move_data,
    input logic [DATA_W-1:0] hi_q,
    input logic [DATA_W-1:0] lo_q
);
    localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(NREGS - 1);

    a_r1_result_clear: assert property (@(posedge clk)
        rst |=> (hi_q == '0 && lo_q == '0));

    a_r3_zero_port_a: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    a_r3_zero_port_b: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    a_r4_bypass_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !link_en && (wr_sel == 2'd0 || wr_sel == 2'd3)
         && wr_addr == rd_addr_a && wr_addr != '0) |-> (rd_data_a == wr_data));

    a_r5_link_visible: assert property (@(posedge clk) disable iff (rst)
        (link_en && rd_addr_b == TOP_IDX) |-> (rd_data_b == link_data));

    a_r7_pair_load: assert property (@(posedge clk) disable iff (rst)
        (hl_op == 2'd1) |=> (hi_q == $past(prod_hi) && lo_q == $past(prod_lo)));

    a_r8_hi_only: assert property (@(posedge clk) disable iff (rst)
        (hl_op == 2'd2) |=> (hi_q == $past(hl_move_data) && $stable(lo_q)));

    a_r8_lo_only: assert property (@(posedge clk) disable iff (rst)
        (hl_op == 2'd3) |=> (lo_q == $past(hl_move_data) && $stable(hi_q)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (hl_op == 2'd0) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind gpr_bank gpr_bank_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) i_chk (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel), .wr_data(wr_data),
    .link_en(link_en), .link_data(link_data),
    .hl_op(hl_op), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .hl_move_data(hl_move_data), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, hi_q, lo_q;
    logic        wr_en = 1'b0, link_en = 1'b0;
    logic [1:0]  wr_sel = '0, hl_op = '0;
    logic [31:0] wr_data = '0, link_data = '0, prod_hi = '0, prod_lo = '0, hl_move_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_reg [32];
    logic [31:0] m_hi, m_lo;

    gpr_bank i_gpr_bank (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data),
        .hl_op(hl_op), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .hl_move_data(hl_move_data), .hi_q(hi_q), .lo_q(lo_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // effective write computed from the requirements (R5, R6, R9, R10)
    function automatic logic eff_we();
        return !rst && (link_en || wr_en);
    endfunction
    function automatic logic [4:0] eff_addr();
        return link_en ? 5'd31 : wr_addr;
    endfunction
    function automatic logic [31:0] eff_data();
        if (link_en) return link_data;
        if (wr_sel == 2'd1) return m_hi;
        if (wr_sel == 2'd2) return m_lo;
        return wr_data;
    endfunction
    function automatic logic [31:0] exp_read(logic [4:0] a);
        if (a == 5'd0) return '0;                                 // R3
        if (eff_we() && eff_addr() == a) return eff_data();       // R4
        return m_reg[a];                                          // R2
    endfunction

    task automatic idle();
        wr_en = 0; link_en = 0; hl_op = 2'd0; wr_sel = 2'd0;
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic cycle(string tag);
        logic        we_n;
        logic [4:0]  wa_n;
        logic [31:0] wd_n, hi_n, lo_n;
        #1;
        if (!rst) begin
            check({tag, " R4 port A"}, rd_data_a, exp_read(rd_addr_a));
            check({tag, " R4 port B"}, rd_data_b, exp_read(rd_addr_b));
        end
        we_n = eff_we(); wa_n = eff_addr(); wd_n = eff_data();
        hi_n = m_hi; lo_n = m_lo;
        if (hl_op == 2'd1) begin hi_n = prod_hi; lo_n = prod_lo; end       // R7
        if (hl_op == 2'd2) hi_n = hl_move_data;                            // R8
        if (hl_op == 2'd3) lo_n = hl_move_data;                            // R8
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 32; i++) m_reg[i] = '0;
            m_hi = '0; m_lo = '0;
        end else begin
            if (we_n && wa_n != 0) m_reg[wa_n] = wd_n;
            m_hi = hi_n; m_lo = lo_n;
        end
        #1;
        if (!rst) begin
            check({tag, " R7/R8 upper"}, hi_q, m_hi);
            check({tag, " R7/R8 lower"}, lo_q, m_lo);
        end
        @(negedge clk);
    endtask

    task automatic read_pair(string tag, logic [4:0] a, logic [4:0] b);
        idle(); rd_addr_a = a; rd_addr_b = b;
        #1;
        check({tag, " port A"}, rd_data_a, exp_read(a));
        check({tag, " port B"}, rd_data_b, exp_read(b));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 32; i++) m_reg[i] = 'x;
        m_hi = 'x; m_lo = 'x;
        @(negedge clk);
        rst = 1; idle(); wr_en = 1; wr_addr = 5'd7; wr_data = 32'hdead_beef;
        cycle("reset");
        cycle("reset");
        rst = 0; idle();

        // R1: every register and both result registers read zero after reset
        for (int i = 0; i < 32; i += 2) read_pair("R1 cleared", 5'(i), 5'(i + 1));
        check("R1 upper cleared", hi_q, 32'h0);
        check("R1 lower cleared", lo_q, 32'h0);

        // R2: plain write then read
        idle(); wr_en = 1; wr_addr = 5'd5; wr_data = 32'h1234_5678;
        rd_addr_a = 5'd6; rd_addr_b = 5'd4; cycle("R2 write");
        read_pair("R2 readback", 5'd5, 5'd5);
        check("R2 reg5", rd_data_a, 32'h1234_5678);

        // R3: write to index 0 has no effect
        idle(); wr_en = 1; wr_addr = 5'd0; wr_data = 32'hffff_ffff;
        rd_addr_a = 5'd0; rd_addr_b = 5'd0; cycle("R3 write zero");
        read_pair("R3 after", 5'd0, 5'd0);
        check("R3 reg0", rd_data_b, 32'h0);

        // R4: same-cycle bypass on both ports
        idle(); wr_en = 1; wr_addr = 5'd9; wr_data = 32'hcafe_f00d;
        rd_addr_a = 5'd9; rd_addr_b = 5'd9; #1;
        check("R4 bypass A", rd_data_a, 32'hcafe_f00d);
        check("R4 bypass B", rd_data_b, 32'hcafe_f00d);
        cycle("R4");

        // R5 and R6: link collides with explicit write to another index
        idle(); link_en = 1; link_data = 32'h0040_0100;
        wr_en = 1; wr_addr = 5'd12; wr_data = 32'h0bad_0bad;
        rd_addr_a = 5'd12; rd_addr_b = 5'd31; cycle("R6 collide");
        read_pair("R5 link", 5'd31, 5'd12);
        check("R5 reg31", rd_data_a, 32'h0040_0100);
        check("R6 reg12 untouched", rd_data_b, 32'h0);

        // R6: explicit write also to register 31
        idle(); link_en = 1; link_data = 32'h0000_2222;
        wr_en = 1; wr_addr = 5'd31; wr_data = 32'h9999_9999; cycle("R6 same idx");
        read_pair("R6 after", 5'd31, 5'd1);
        check("R6 reg31 link wins", rd_data_a, 32'h0000_2222);

        // R7: pair load
        idle(); hl_op = 2'd1; prod_hi = 32'haaaa_0001; prod_lo = 32'h5555_0002; cycle("R7");
        check("R7 upper", hi_q, 32'haaaa_0001);
        check("R7 lower", lo_q, 32'h5555_0002);

        // R8: single moves
        idle(); hl_op = 2'd2; hl_move_data = 32'h1111_1111; cycle("R8 hi");
        check("R8 upper set", hi_q, 32'h1111_1111);
        check("R8 lower kept", lo_q, 32'h5555_0002);
        idle(); hl_op = 2'd3; hl_move_data = 32'h2222_2222; cycle("R8 lo");
        check("R8 lower set", lo_q, 32'h2222_2222);
        check("R8 upper kept", hi_q, 32'h1111_1111);

        // R9: move-from uses the value before the edge, while a pair load happens
        idle(); wr_en = 1; wr_sel = 2'd1; wr_addr = 5'd20;
        hl_op = 2'd1; prod_hi = 32'h7777_7777; prod_lo = 32'h8888_8888; cycle("R9 hi");
        idle(); wr_en = 1; wr_sel = 2'd2; wr_addr = 5'd21; cycle("R9 lo");
        read_pair("R9 read", 5'd20, 5'd21);
        check("R9 from upper", rd_data_a, 32'h1111_1111);
        check("R9 from lower", rd_data_b, 32'h8888_8888);

        // R10: disabled write
        idle(); wr_addr = 5'd5; wr_data = 32'h0; cycle("R10");
        read_pair("R10 read", 5'd5, 5'd31);
        check("R10 reg5 kept", rd_data_a, 32'h1234_5678);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 100;
            wr_en     = ($urandom % 3) != 0;
            link_en   = ($urandom % 8) == 0;
            wr_sel    = 2'($urandom);
            wr_addr   = 5'($urandom);
            wr_data   = $urandom;
            link_data = $urandom;
            hl_op     = 2'($urandom);
            prod_hi   = $urandom;
            prod_lo   = $urandom;
            hl_move_data = $urandom;
            rd_addr_a = (r < 25) ? wr_addr : 5'($urandom);
            rd_addr_b = (r > 85) ? 5'd31 : ((r > 75) ? 5'd0 : 5'($urandom));
            cycle("random");
        end
        for (int i = 0; i < 32; i += 2) read_pair("R2 final sweep", 5'(i), 5'(i + 1));

        // R1 again: reset after activity
        rst = 1; idle(); cycle("reset2"); rst = 0;
        for (int i = 0; i < 32; i += 2) read_pair("R1 re-reset", 5'(i), 5'(i + 1));
        check("R1 upper re-reset", hi_q, 32'h0);
        check("R1 lower re-reset", lo_q, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule